// File: doc/BRIEF.md
# Clause-22 MDIO Management Master

This block runs management transactions to an Ethernet PHY over the two-wire MDC/MDIO interface. Software starts a transaction with a single 32-bit write to the command/data register. That word already holds the whole frame: the start code, the opcode, the PHY address, the register address, the turnaround code and, for a write, the 16 data bits. The block first sends a 32-bit preamble of ones, which it never skips. It then shifts the 32 command bits out, most significant bit first.

For a read frame, the block stops driving MDIO during the turnaround and data phase. It samples the 16 bits the PHY returns on each rising edge of MDC and places them in the low half of the same register. When the last bit has gone, a sticky completion event is raised in bit 23 of the event register. Software clears the event by writing a 1 to that bit.

MDC is made from the system clock. Each MDC half period lasts a programmed number of system clock cycles, so one MDC period is twice the programmed value in clock cycles. Software picks the value so that MDC stays at or below about 2.5 MHz.

Top module: `mdio_master`

## Requirements
- R1: After reset the command/data register reads 0, the event register reads 0, MDC is low and the MDIO driver is disabled.
- R2: A command word written while idle is accepted at once. The frame is 32 ones followed by the 32 command bits, bit 31 first, 64 bits in all. Each bit is presented for one MDC period and changes only when MDC falls.
- R3: Each MDC half period lasts `mdc_half` system clock cycles, and a value of 0 acts as 1. MDC stays low whenever no frame is in progress.
- R4: When the opcode field (bits 29:28) is not 2'b10, the frame is a write frame and the MDIO driver is enabled for all 64 bits.
- R5: When bits 29:28 equal 2'b10, the frame is a read frame. MDIO is driven through the register address field (frame bit 46 onward is released) and stays released for the last 18 bits. The final 16 bits are sampled on rising MDC edges into bits 15:0 of the command/data register, first bit into bit 15, while bits 31:16 keep the command.
- R6: Event bit 23 becomes set on the clock edge that ends the last frame bit. It is first visible 128 x (effective half period) clock edges after the edge that accepted the command.
- R7: Writing the event register with bit 23 set clears the event, and a write with bit 23 clear leaves it unchanged. If completion and a clearing write land on the same edge, the event ends set.
- R8: A command written while a frame is in progress is ignored. The register contents and the frame on the wire are unaffected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_we | input | 1 | Write strobe for the command/data register |
| cmd_wdata | input | 32 | Command word to launch |
| cmd_rdata | output | 32 | Command/data register contents |
| evt_we | input | 1 | Write strobe for the event register |
| evt_wdata | input | 32 | Event write value; a 1 in bit 23 clears completion |
| evt_rdata | output | 32 | Event register; bit 23 is completion |
| mdc_half | input | 6 | MDC half period in system clock cycles |
| mdc | output | 1 | Management clock to the PHY |
| mdio_o | output | 1 | MDIO output value |
| mdio_oe | output | 1 | MDIO output enable |
| mdio_i | input | 1 | MDIO input value |

## Verification
A wrong bit index or a bad opcode decode shows up within one MDC period: a wrong value or enable on MDIO is seen at the very next rising MDC edge. A divider fault shows as a wrong spacing between MDC edges from the first half period on, and the completion event then arrives at the wrong cycle. A lost or wrongly merged read bit only shows in the low half of the register after completion. The bench therefore checks every MDC edge, the exact completion cycle and the register contents afterwards.

// File: rtl/mdio_pkg.sv
package mdio_pkg;

    localparam int CMD_W       = 32;
    localparam int RD_W        = 16;
    localparam int EVT_DONE    = 23;
    localparam int OP_MSB      = 29;
    localparam int OP_LSB      = 28;
    localparam logic [1:0] OP_READ = 2'b10;
    localparam logic [CMD_W-1:0] EVT_MASK = CMD_W'(1) << EVT_DONE;

    // Opcode 2'b10 is a read; any other code shifts out as a write.
    function automatic logic is_read(input logic [CMD_W-1:0] cmd);
        return cmd[OP_MSB:OP_LSB] == OP_READ;
    endfunction

endpackage

// File: rtl/mdio_mdc_gen.sv
module mdio_mdc_gen #(
    parameter int SPD_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [SPD_W-1:0] half,
    output logic             mdc,
    output logic             rise_now,
    output logic             fall_now
);

    typedef struct packed {
        logic [SPD_W-1:0] cnt;
        logic             mdc;
    } gen_t;

    gen_t             s_d, s_q;
    logic [SPD_W-1:0] lim;
    logic             edge_now;

    always_comb begin
        lim      = (half == '0) ? SPD_W'(1) : half;
        s_d      = s_q;
        edge_now = 1'b0;
        if (!run) begin
            s_d.cnt = '0;
            s_d.mdc = 1'b0;
        end else if (s_q.cnt >= lim - SPD_W'(1)) begin
            edge_now = 1'b1;
            s_d.cnt  = '0;
            s_d.mdc  = ~s_q.mdc;
        end else begin
            s_d.cnt = s_q.cnt + SPD_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign mdc      = s_q.mdc;
    assign rise_now = edge_now & ~s_q.mdc;
    assign fall_now = edge_now &  s_q.mdc;

    AST_STOP_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> !mdc);  // R3

endmodule

// File: rtl/mdio_frame_seq.sv
module mdio_frame_seq
    import mdio_pkg::*;
#(
    parameter int PRE_BITS = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [CMD_W-1:0] cmd,
    input  logic             rise_now,
    input  logic             fall_now,
    input  logic             mdio_i,
    output logic             active,
    output logic             mdio_o,
    output logic             mdio_oe,
    output logic             done,
    output logic [RD_W-1:0]  rdata
);

    localparam int FRAME_BITS = PRE_BITS + CMD_W;
    localparam int IDX_W      = $clog2(FRAME_BITS);
    localparam int RLS_IDX    = PRE_BITS + 14;   // first turnaround bit
    localparam int SMP_IDX    = PRE_BITS + 16;   // first returned data bit

    typedef struct packed {
        logic             active;
        logic             rd;
        logic [IDX_W-1:0] idx;
        logic [CMD_W-1:0] frame;
        logic [RD_W-1:0]  rdata;
    } seq_t;

    seq_t       s_d, s_q;
    logic [4:0] pos;

    always_comb begin
        s_d  = s_q;
        done = 1'b0;
        if (s_q.active) begin
            if (rise_now && s_q.rd && s_q.idx >= IDX_W'(SMP_IDX))
                s_d.rdata = {s_q.rdata[RD_W-2:0], mdio_i};
            if (fall_now) begin
                if (s_q.idx == IDX_W'(FRAME_BITS - 1)) begin
                    s_d.active = 1'b0;
                    done       = 1'b1;
                end else begin
                    s_d.idx = s_q.idx + IDX_W'(1);
                end
            end
        end else if (start) begin
            s_d.active = 1'b1;
            s_d.rd     = is_read(cmd);
            s_d.idx    = '0;
            s_d.frame  = cmd;
            s_d.rdata  = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign pos     = 5'(IDX_W'(FRAME_BITS - 1) - s_q.idx);
    assign active  = s_q.active;
    assign rdata   = s_q.rdata;
    assign mdio_o  = (!s_q.active || s_q.idx < IDX_W'(PRE_BITS)) ? 1'b1 : s_q.frame[pos];
    assign mdio_oe = s_q.active && (!s_q.rd || s_q.idx < IDX_W'(RLS_IDX));

    AST_PREAMBLE_ONES: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.active && s_q.idx < IDX_W'(PRE_BITS)) |-> (mdio_oe && mdio_o));  // R2

    AST_READ_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.active && s_q.rd && s_q.idx >= IDX_W'(RLS_IDX)) |-> !mdio_oe);  // R5

    AST_WRITE_DRIVEN: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.active && !s_q.rd) |-> mdio_oe);  // R4

endmodule

// File: rtl/mdio_master.sv
module mdio_master
    import mdio_pkg::*;
#(
    parameter int SPD_W    = 6,
    parameter int PRE_BITS = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_we,
    input  logic [31:0]      cmd_wdata,
    output logic [31:0]      cmd_rdata,
    input  logic             evt_we,
    input  logic [31:0]      evt_wdata,
    output logic [31:0]      evt_rdata,
    input  logic [SPD_W-1:0] mdc_half,
    output logic             mdc,
    output logic             mdio_o,
    output logic             mdio_oe,
    input  logic             mdio_i
);

    typedef struct packed {
        logic [CMD_W-1:0] data;
        logic             evt;
    } top_t;

    top_t            s_d, s_q;
    logic            busy, start, done, rise_now, fall_now, evt_clr;
    logic [RD_W-1:0] rdata;

    assign start   = cmd_we && !busy;
    assign evt_clr = evt_we && ((evt_wdata & EVT_MASK) != '0);

    mdio_mdc_gen #(.SPD_W(SPD_W)) u_gen (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (busy),
        .half     (mdc_half),
        .mdc      (mdc),
        .rise_now (rise_now),
        .fall_now (fall_now)
    );

    mdio_frame_seq #(.PRE_BITS(PRE_BITS)) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .cmd      (cmd_wdata),
        .rise_now (rise_now),
        .fall_now (fall_now),
        .mdio_i   (mdio_i),
        .active   (busy),
        .mdio_o   (mdio_o),
        .mdio_oe  (mdio_oe),
        .done     (done),
        .rdata    (rdata)
    );

    always_comb begin
        s_d = s_q;
        if (start)
            s_d.data = cmd_wdata;
        if (done && is_read(s_q.data))
            s_d.data[RD_W-1:0] = rdata;
        if (evt_clr)
            s_d.evt = 1'b0;
        if (done)
            s_d.evt = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign cmd_rdata = s_q.data;
    assign evt_rdata = s_q.evt ? EVT_MASK : '0;

    AST_EVT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.evt && !evt_clr) |=> s_q.evt);  // R7

    AST_EVT_FROM_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(s_q.evt) |-> $past(busy));  // R6

    AST_BUSY_CMD_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && cmd_we && !done) |=> (s_q.data == $past(s_q.data)));  // R8

    AST_MDC_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mdc);  // R3

endmodule

// File: tb/tb_mdio_master.sv
module tb_mdio_master;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_we = 1'b0;
    logic [31:0] cmd_wdata = '0;
    logic [31:0] cmd_rdata;
    logic        evt_we = 1'b0;
    logic [31:0] evt_wdata = '0;
    logic [31:0] evt_rdata;
    logic [5:0]  mdc_half = 6'd1;
    logic        mdc, mdio_o, mdio_oe;
    logic        mdio_i = 1'b1;

    int total = 0;
    int bad = 0;

    // monitor / responder state
    int          rises = 0;
    int          gap = 0;
    int          hp_bad = 0;
    int          hp_exp = 1;
    bit          have_prev = 0;
    logic        prev_mdc = 1'b0;
    logic        oe_rec [64];
    logic        o_rec  [64];
    logic [15:0] resp_data = '0;

    always #4 clk = ~clk;

    mdio_master dut (
        .clk(clk), .rst_n(rst_n),
        .cmd_we(cmd_we), .cmd_wdata(cmd_wdata), .cmd_rdata(cmd_rdata),
        .evt_we(evt_we), .evt_wdata(evt_wdata), .evt_rdata(evt_rdata),
        .mdc_half(mdc_half), .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe),
        .mdio_i(mdio_i)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
        end
    endtask

    function automatic bit exp_is_read(input logic [31:0] c);
        return c[29:28] == 2'b10;
    endfunction

    function automatic logic [31:0] exp_data(input logic [31:0] c, input logic [15:0] r);
        return exp_is_read(c) ? {c[31:16], r} : c;
    endfunction

    always @(negedge clk) begin
        gap++;
        if (mdc != prev_mdc) begin
            if (have_prev && gap != hp_exp) hp_bad++;
            have_prev = 1;
            gap = 0;
        end
        if (mdc && !prev_mdc) begin
            if (rises < 64) begin
                oe_rec[rises] = mdio_oe;
                o_rec[rises]  = mdio_o;
            end
            rises++;
            mdio_i = (rises >= 48 && rises <= 63) ? resp_data[63 - rises] : 1'b1;
        end
        prev_mdc = mdc;
    end

    task automatic run_frame(input logic [31:0] cmd, input int spd, input logic [15:0] resp,
                             input bit poke, input bit collide);
        int s = (spd == 0) ? 1 : spd;
        int cyc;
        int bits_bad = 0;
        int oe_bad = 0;
        @(negedge clk);
        mdc_half  = 6'(spd);
        hp_exp    = s;
        resp_data = resp;
        rises     = 0;
        have_prev = 0;
        mdio_i    = 1'b1;
        cmd_we    = 1'b1;
        cmd_wdata = cmd;
        @(negedge clk);
        cmd_we = 1'b0;
        cyc = 1;
        while (!evt_rdata[23] && cyc < 2000) begin
            if (poke && cyc == 40) begin
                cmd_we = 1'b1;
                cmd_wdata = ~cmd;
            end else begin
                cmd_we = 1'b0;
            end
            if (collide && cyc == 128 * s) begin
                evt_we = 1'b1;
                evt_wdata = 32'h0080_0000;
            end else begin
                evt_we = 1'b0;
            end
            @(negedge clk);
            cyc++;
        end
        cmd_we = 1'b0;
        evt_we = 1'b0;
        chk(cyc == 128 * s + 1, "R6 completion cycle", cyc, 128 * s + 1);
        chk(rises == 64, "R2 MDC rising edges per frame", rises, 64);
        chk(hp_bad == 0, "R3 MDC half period", hp_bad, 0);
        hp_bad = 0;
        for (int r = 0; r < 64; r++) begin
            if (r < 32) begin
                if (!(oe_rec[r] && o_rec[r])) bits_bad++;
            end else if (!exp_is_read(cmd) || r < 46) begin
                if (!oe_rec[r] || o_rec[r] !== cmd[63 - r]) bits_bad++;
            end else begin
                if (oe_rec[r] !== 1'b0) oe_bad++;
            end
        end
        chk(bits_bad == 0, exp_is_read(cmd) ? "R2 read frame bits" : "R4 write frame bits", bits_bad, 0);
        chk(oe_bad == 0, "R5 turnaround and data released", oe_bad, 0);
        chk(cmd_rdata == exp_data(cmd, resp), poke ? "R8 register after ignored write" : "R5 register after frame",
            cmd_rdata, exp_data(cmd, resp));
        chk(evt_rdata == 32'h0080_0000, collide ? "R7 set wins over clear" : "R6 event set", evt_rdata, 32'h0080_0000);
        chk(!mdc && !mdio_oe, "R3 idle after frame", {30'd0, mdc, mdio_oe}, 0);
    endtask

    task automatic evt_write(input logic [31:0] v);
        @(negedge clk);
        evt_we = 1'b1;
        evt_wdata = v;
        @(negedge clk);
        evt_we = 1'b0;
    endtask

    function automatic logic [31:0] mk_cmd(input logic [1:0] op, input logic [4:0] pa,
                                           input logic [4:0] ra, input logic [15:0] d);
        return {2'b01, op, pa, ra, 2'b10, d};
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        bad++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(cmd_rdata == 0, "R1 data reset", cmd_rdata, 0);
        chk(evt_rdata == 0, "R1 event reset", evt_rdata, 0);
        chk(!mdc && !mdio_oe, "R1 pins reset", {30'd0, mdc, mdio_oe}, 0);

        // directed corners
        run_frame(mk_cmd(2'b01, 5'd1, 5'd0, 16'h8000), 1, 16'h0, 0, 0);   // R4 write
        evt_write(32'h0000_0000);
        chk(evt_rdata == 32'h0080_0000, "R7 write of zero keeps event", evt_rdata, 32'h0080_0000);
        evt_write(32'hFF7F_FFFF);
        chk(evt_rdata == 32'h0080_0000, "R7 other bits keep event", evt_rdata, 32'h0080_0000);
        evt_write(32'h0080_0000);
        chk(evt_rdata == 0, "R7 clear by one", evt_rdata, 0);

        run_frame(mk_cmd(2'b10, 5'd31, 5'd31, 16'h0), 2, 16'hFFFF, 0, 0); // R5 all ones
        evt_write(32'h0080_0000);
        run_frame(mk_cmd(2'b10, 5'd0, 5'd1, 16'hFFFF), 3, 16'h0000, 0, 0); // R5 zeros
        evt_write(32'h0080_0000);
        run_frame(mk_cmd(2'b01, 5'd5, 5'd4, 16'h01E1), 0, 16'h0, 0, 0);    // R3 zero speed
        evt_write(32'h0080_0000);
        run_frame(mk_cmd(2'b11, 5'd9, 5'd2, 16'hA5A5), 1, 16'h0, 0, 0);    // R4 other opcode
        evt_write(32'h0080_0000);
        run_frame(mk_cmd(2'b10, 5'd3, 5'd1, 16'h0), 2, 16'h7949, 1, 0);    // R8 read
        evt_write(32'h0080_0000);
        run_frame(mk_cmd(2'b01, 5'd3, 5'd0, 16'h1200), 1, 16'h0, 1, 0);    // R8 write
        evt_write(32'h0080_0000);
        run_frame(mk_cmd(2'b01, 5'd7, 5'd7, 16'h5A5A), 2, 16'h0, 0, 1);    // R7 collision

        // random frames, event left pending between some
        for (int k = 0; k < 10; k++) begin
            logic [31:0] c;
            c = mk_cmd(($urandom % 2) ? 2'b10 : 2'b01, 5'($urandom), 5'($urandom), 16'($urandom));
            evt_write(32'h0080_0000);
            chk(evt_rdata == 0, "R7 cleared before frame", evt_rdata, 0);
            run_frame(c, 1 + int'($urandom % 5), 16'($urandom), 0, 0);
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule